// File: doc/BRIEF.md
# Supply-Loss Access Gate for Battery-Backed Memory

This block sits between a bus master and a battery-backed static memory and decides, cycle by cycle, whether a chip-enable or a write strobe may reach the array. External comparators report three digital conditions: the supply has dropped into the deselect window, the supply has dropped below the level where the battery takes over, and the battery itself is weak. The block turns these into a qualified chip enable, a qualified write strobe and a read-drive permit. While power is bad, it blocks every access. After power comes back, it keeps the memory locked for a programmable number of clock cycles.

When the block leaves the power-fail state, it samples the weak-battery input once and holds the result as a status bit. Software can read this bit at any time. While the bit is set, the first write request that reaches the memory is swallowed. When that request ends, the bit clears by itself and later writes go through. The idea is that a program writes a test pattern and reads it back to learn whether the stored contents can still be trusted.

Top module: `pfg_gate`

## Requirements
- R1: During reset and immediately after it, all three qualified outputs are 0 and `batt_bad` is 0. The block stays in the power-fail state until `pf_low` is sampled low.
- R2: In any cycle where `pf_low` or `so_low` is 1, `ce_q`, `we_q` and `oe_ok` are 0 in that same cycle. A write in progress is therefore cut off at once.
- R3: Call the first clock edge at which `pf_low` is sampled 0 edge 1. Accesses stay blocked through edge T_REC, and the gate opens after edge T_REC+1.
- R4: If `pf_low` is 1 at any edge during recovery, the recovery count is discarded. The full T_REC delay then restarts once `pf_low` is low again.
- R5: `batt_bad` takes the value of `batt_low` at the edge where the block leaves the power-fail state (edge 1 of R3).
- R6: While the gate is open, `batt_bad` is not resampled from `batt_low`, and reads do not clear it.
- R7: While `batt_bad` is 1, `we_q` stays 0 even though `ce_req` and `we_req` are both 1.
- R8: After a write request (`ce_req`=1 and `we_req`=1) has been seen while the gate is open and `batt_bad` is 1, `batt_bad` clears at the first edge where that request is no longer present. The next write passes.
- R9: With the gate open and `batt_bad`=0, the outputs follow these equations:
  - `ce_q` = `ce_req`
  - `we_q` = `ce_req` & `we_req`
  - `oe_ok` = `ce_req` & ~`we_req`
- R10: `backup_mode` is 1 exactly when `so_low` is 1, and `ce_q` is then 0.
- R11: While power is failed or recovery is running, `ce_req` and `we_req` have no effect. They produce no qualified outputs and do not clear `batt_bad`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_low | input | 1 | Supply inside the deselect window |
| so_low | input | 1 | Supply below the battery takeover level |
| batt_low | input | 1 | Battery voltage below the health limit |
| ce_req | input | 1 | Chip-enable request from the master |
| we_req | input | 1 | Write request from the master |
| ce_q | output | 1 | Qualified chip enable to the array |
| we_q | output | 1 | Qualified write strobe to the array |
| oe_ok | output | 1 | Permit for the array to drive read data |
| batt_bad | output | 1 | Latched weak-battery status |
| backup_mode | output | 1 | Memory is running from the battery |

## Verification
The bench checks the exact edge at which the gate opens. A counter that is off by one would grant an access one cycle early or late. It drops the supply partway through recovery, which catches a counter that resumes instead of restarting. It changes `batt_low` after power-up and holds a blocked write over several cycles, which exposes a flag that is resampled, cleared by reads, or cleared before the request ends. It also raises the power-fail input in the middle of a write, which exposes a registered gate that would let one more strobe cycle reach the array.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  typedef enum logic [1:0] {
    PW_OFF = 2'd0,
    PW_REC = 2'd1,
    PW_RUN = 2'd2
  } pw_state_e;

  // recovery finishes when the count reaches limit-1 (count starts at 0)
  function automatic logic rec_expired(input logic [31:0] cnt,
                                       input logic [31:0] limit);
    return (cnt + 32'd1) >= limit;
  endfunction

  // gate open only in run state with both supply flags clear
  function automatic logic gate_open(input pw_state_e st,
                                     input logic pf, input logic so);
    return (st == PW_RUN) && !pf && !so;
  endfunction

endpackage

// File: rtl/pfg_recovery.sv
module pfg_recovery
  import pfg_pkg::*;
#(
  parameter int T_REC = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pf_low,
  output pw_state_e state,
  output logic      leave_off,
  output logic      run_st
);
  localparam int CNT_W = (T_REC < 2) ? 1 : $clog2(T_REC + 1);

  logic [CNT_W-1:0] cnt;

  assign leave_off = (state == PW_OFF) && !pf_low;
  assign run_st    = (state == PW_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PW_OFF;
      cnt   <= '0;
    end else if (pf_low) begin
      state <= PW_OFF;
      cnt   <= '0;
    end else begin
      unique case (state)
        PW_OFF: begin
          state <= PW_REC;
          cnt   <= '0;
        end
        PW_REC: begin
          if (rec_expired(32'(cnt), 32'(T_REC))) state <= PW_RUN;
          else cnt <= cnt + 1'b1;
        end
        default: state <= PW_RUN;
      endcase
    end
  end

endmodule

// File: rtl/pfg_batt_flag.sv
module pfg_batt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic leave_off,
  input  logic open,
  input  logic wr_req,
  input  logic batt_low,
  output logic flag,
  output logic blk_done
);
  logic pend;

  assign blk_done = pend && !wr_req && open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      pend <= 1'b0;
    end else if (leave_off) begin
      flag <= batt_low;
      pend <= 1'b0;
    end else if (!open) begin
      pend <= 1'b0;
    end else if (blk_done) begin
      flag <= 1'b0;
      pend <= 1'b0;
    end else if (flag && wr_req) begin
      pend <= 1'b1;
    end
  end

endmodule

// File: rtl/pfg_gate.sv
module pfg_gate
  import pfg_pkg::*;
#(
  parameter int T_REC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pf_low,
  input  logic so_low,
  input  logic batt_low,
  input  logic ce_req,
  input  logic we_req,
  output logic ce_q,
  output logic we_q,
  output logic oe_ok,
  output logic batt_bad,
  output logic backup_mode
);
  pw_state_e state;
  logic      leave_off;
  logic      run_st;
  logic      open;
  logic      wr_req;
  logic      blk_done;

  pfg_recovery #(.T_REC(T_REC)) u_rec (
    .clk      (clk),
    .rst_n    (rst_n),
    .pf_low   (pf_low),
    .state    (state),
    .leave_off(leave_off),
    .run_st   (run_st)
  );

  assign open   = gate_open(state, pf_low, so_low);
  assign wr_req = ce_req && we_req && open;

  pfg_batt_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .leave_off(leave_off),
    .open     (open),
    .wr_req   (wr_req),
    .batt_low (batt_low),
    .flag     (batt_bad),
    .blk_done (blk_done)
  );

  assign ce_q        = ce_req && open;
  assign we_q        = wr_req && !batt_bad;
  assign oe_ok       = ce_req && !we_req && open;
  assign backup_mode = so_low;

endmodule

// File: rtl/pfg_gate_chk.sv
module pfg_gate_chk #(
  parameter int T_REC = 16
) (
  input logic clk,
  input logic rst_n,
  input logic pf_low,
  input logic so_low,
  input logic batt_low,
  input logic ce_req,
  input logic we_req,
  input logic ce_q,
  input logic we_q,
  input logic oe_ok,
  input logic batt_bad,
  input logic backup_mode,
  input logic leave_off,
  input logic run_st
);
  localparam int LW = $clog2(T_REC + 2) + 1;
  localparam logic [LW-1:0] NEED = LW'(T_REC + 1);

  // edges in a row with the supply good, saturating
  logic [LW-1:0] lowcnt;
  always_ff @(posedge clk) begin
    if (!rst_n || pf_low) lowcnt <= '0;
    else if (lowcnt != NEED) lowcnt <= lowcnt + 1'b1;
  end

  p_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_low || so_low) |-> (!ce_q && !we_q && !oe_ok));

  p_recovery_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_st |-> (lowcnt == NEED));

  p_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(batt_bad) |-> ($past(leave_off) && $past(batt_low)));

  p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    batt_bad |-> !we_q);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(batt_bad) |-> ($past(!(ce_req && we_req)) || $past(leave_off)));

  p_backup_r10: assert property (@(posedge clk) disable iff (!rst_n)
    so_low |-> (backup_mode && !ce_q));

endmodule

bind pfg_gate pfg_gate_chk #(.T_REC(T_REC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pf_low     (pf_low),
  .so_low     (so_low),
  .batt_low   (batt_low),
  .ce_req     (ce_req),
  .we_req     (we_req),
  .ce_q       (ce_q),
  .we_q       (we_q),
  .oe_ok      (oe_ok),
  .batt_bad   (batt_bad),
  .backup_mode(backup_mode),
  .leave_off  (leave_off),
  .run_st     (run_st)
);

// File: tb/pfg_gate_bench.sv
module pfg_gate_bench;
  localparam int TREC = 12;

  logic clk = 1'b0;
  logic rst_n, pf_low, so_low, batt_low, ce_req, we_req;
  logic ce_q, we_q, oe_ok, batt_bad, backup_mode;
  int   checks = 0;
  int   errors = 0;

  always #10 clk = ~clk;

  pfg_gate #(.T_REC(TREC)) u_pfg_gate (
    .clk(clk), .rst_n(rst_n), .pf_low(pf_low), .so_low(so_low),
    .batt_low(batt_low), .ce_req(ce_req), .we_req(we_req),
    .ce_q(ce_q), .we_q(we_q), .oe_ok(oe_ok), .batt_bad(batt_bad),
    .backup_mode(backup_mode)
  );

  // [4] ce_req [3] we_req [2] ce_q [1] we_q [0] oe_ok, gate open, flag clear
  localparam logic [4:0] VEC [6] = '{
    5'b00_000, 5'b10_101, 5'b11_110, 5'b01_000, 5'b11_110, 5'b10_101
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; pf_low = 1; so_low = 1; batt_low = 0; ce_req = 1; we_req = 1;
    tick(3);
    #1;
    chk("R1 ce_q in reset", ce_q, 1'b0);
    chk("R1 we_q in reset", we_q, 1'b0);
    chk("R1 batt_bad in reset", batt_bad, 1'b0);
    rst_n = 1; ce_req = 1; we_req = 0;
    tick(1); #1;
    chk("R1 ce_q after reset", ce_q, 1'b0);

    // power returns with a weak battery
    pf_low = 0; so_low = 0; batt_low = 1;
    tick(1); #1;
    chk("R5 flag latched at leave", batt_bad, 1'b1);
    chk("R3 locked edge1", ce_q, 1'b0);
    we_req = 1;
    #1 chk("R11 write ignored in recovery", we_q, 1'b0);
    tick(1); #1;
    we_req = 0;
    chk("R11 flag kept after recovery write", batt_bad, 1'b1);
    tick(TREC - 2); #1;
    chk("R3 locked at edge T_REC", ce_q, 1'b0);
    tick(1); #1;
    chk("R3 open after edge T_REC+1", ce_q, 1'b1);
    chk("R3 oe_ok open", oe_ok, 1'b1);

    batt_low = 0;
    tick(3); #1;
    chk("R6 flag not resampled nor read-cleared", batt_bad, 1'b1);

    we_req = 1;
    #1 chk("R7 write blocked", we_q, 1'b0);
    chk("R7 ce still passes", ce_q, 1'b1);
    tick(2); #1;
    chk("R8 flag held while request on", batt_bad, 1'b1);
    chk("R7 still blocked", we_q, 1'b0);
    we_req = 0;
    tick(1); #1;
    chk("R8 flag cleared after request ends", batt_bad, 1'b0);
    we_req = 1;
    #1 chk("R8 next write passes", we_q, 1'b1);

    for (int i = 0; i < 6; i++) begin
      tick(1);
      ce_req = VEC[i][4]; we_req = VEC[i][3];
      #1;
      chk("R9 ce_q", ce_q, VEC[i][2]);
      chk("R9 we_q", we_q, VEC[i][1]);
      chk("R9 oe_ok", oe_ok, VEC[i][0]);
    end

    // power fails mid-write
    tick(1);
    ce_req = 1; we_req = 1;
    #1 chk("R9 write before fail", we_q, 1'b1);
    pf_low = 1;
    #1;
    chk("R2 we_q cut same cycle", we_q, 1'b0);
    chk("R2 ce_q cut same cycle", ce_q, 1'b0);
    so_low = 1;
    #1;
    chk("R10 backup reported", backup_mode, 1'b1);
    chk("R10 ce_q low in backup", ce_q, 1'b0);
    tick(2);
    we_req = 0;
    #1 chk("R11 oe_ok ignored while failed", oe_ok, 1'b0);

    // recovery interrupted and restarted
    so_low = 0;
    #1 chk("R10 backup clears", backup_mode, 1'b0);
    batt_low = 1; pf_low = 0;
    tick(5); #1;
    batt_low = 0;
    chk("R5 weak battery latched", batt_bad, 1'b1);
    pf_low = 1;
    tick(1); #1;
    pf_low = 0;
    tick(1); #1;
    chk("R5 relatched healthy", batt_bad, 1'b0);
    tick(TREC - 1); #1;
    chk("R4 still locked after restart", ce_q, 1'b0);
    tick(1); #1;
    chk("R4 open after full delay", ce_q, 1'b1);
    chk("R4 oe_ok open", oe_ok, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule